// File: doc/BRIEF.md
# Paged Logical-to-Physical Address Translator

This block sits between a processor's 26-bit address bus and the memory system. Each request address falls into one of three regions. The lower 32 MB is logical RAM, which is remapped one page at a time through a programmable table. The next 16 MB is a window onto physical RAM that only supervisor-mode code may use. The top 16 MB holds ROM and I/O. The block returns a translated address, the region code and a data-abort flag.

Physical RAM is always split into 128 pages. A two-bit select sets the page size, and the page size in turn sets how much RAM is installed. Each physical page has one table entry. The entry holds a valid bit and the logical page number at which that physical page appears.

Translation is combinational from the request inputs to the outputs. Table writes are registered, so a write is seen by translation from the next clock edge onward.

Top module: `pagemap_xlate`

## Requirements
- R1: The region code is set by address bits 25:24. Values 00 and 01 give logical RAM (code 0), 10 gives the physical window (code 1), and 11 gives ROM/IO (code 2).
- R2: A logical access translates to 0x2000000 + P*S + (address mod S) when a valid entry for physical page P holds the logical page number (address bits 24:0 divided by S). Here S is the page size, and the abort flag is low.
- R3: A logical access that matches no valid entry raises abort. When abort is raised the output address is zero.
- R4: The page-size select values 0, 1, 2 and 3 give page sizes of 4, 8, 16 and 32 KB. The installed RAM is 128 times the page size.
- R5: When several valid entries hold the same logical page number, the lowest-numbered physical page is used.
- R6: A supervisor access to the physical window below 0x2000000 + 128*S passes through unchanged, with no abort.
- R7: Any access to the physical window while not in supervisor mode raises abort.
- R8: A physical-window access at or above 0x2000000 + 128*S raises abort, even in supervisor mode.
- R9: A ROM/IO access passes the address through and never aborts, in either mode.
- R10: When the word input is 1, the output address has its two lowest bits forced to zero before translation. When the word input is 0 (byte access), all 26 bits are used.
- R11: Reset marks every entry invalid. A table write (page index, valid bit, 13-bit logical page number) changes translation only after the next rising clock edge.
- R12: Writing an entry with the valid bit clear removes that page's mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_size_sel | input | 2 | Page-size select (4/8/16/32 KB) |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_page | input | 7 | Physical page index to write |
| tbl_wr_valid | input | 1 | Valid bit to store |
| tbl_wr_lpage | input | 13 | Logical page number to store |
| req_addr | input | 26 | Request address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_super | input | 1 | 1 = supervisor mode |
| xl_addr | output | 26 | Translated address (zero on abort) |
| xl_region | output | 2 | Region code |
| xl_abort | output | 1 | Data abort |

## Verification
The hardest case to reach from the ports is several valid entries claiming the same logical page. A plain sweep of addresses never creates it. The stimulus builds it on purpose: it maps three physical pages to one logical page, then invalidates the winner so the next-lowest page must take over. A random phase writes logical page numbers from a narrow range so that such collisions keep recurring, and it changes the page size under a live table. A reference model scans the entries on every access and is compared each cycle.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int unsigned LPN_W    = 13;
    localparam int unsigned MIN_OFFB = 12;

    typedef enum logic [1:0] {
        RGN_LOGICAL = 2'd0,
        RGN_PHYSWIN = 2'd1,
        RGN_ROMIO   = 2'd2
    } region_e;

    typedef struct packed {
        logic             valid;
        logic [LPN_W-1:0] lpage;
    } map_entry_t;

    function automatic int unsigned off_bits(input logic [1:0] sel);
        return MIN_OFFB + int'(sel);
    endfunction

endpackage

// File: rtl/xlate_map_table.sv
module xlate_map_table
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 128,
    parameter int unsigned PIDX_W    = $clog2(NUM_PAGES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PIDX_W-1:0]            wr_page,
    input  map_entry_t                   wr_entry,
    output map_entry_t [NUM_PAGES-1:0]   entries
);

    map_entry_t [NUM_PAGES-1:0] table_d;
    map_entry_t [NUM_PAGES-1:0] table_q;

    always_comb begin
        table_d = table_q;
        if (wr_en) begin
            table_d[wr_page] = wr_entry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            table_q <= '0;
        end else begin
            table_q <= table_d;
        end
    end

    assign entries = table_q;

    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> table_q[$past(wr_page)] == $past(wr_entry));

endmodule

// File: rtl/xlate_page_match.sv
module xlate_page_match
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_PAGES = 128,
    parameter int unsigned PIDX_W    = $clog2(NUM_PAGES),
    parameter int unsigned LOG_W     = 25
) (
    input  map_entry_t [NUM_PAGES-1:0] entries,
    input  logic [LOG_W-1:0]           log_addr,
    input  logic [1:0]                 pg_sel,
    output logic                       hit,
    output logic [PIDX_W-1:0]          ppn
);

    logic [LPN_W-1:0]     lpage;
    logic [NUM_PAGES-1:0] hit_vec;

    assign lpage = LPN_W'(log_addr >> off_bits(pg_sel));

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cmp
        assign hit_vec[g] = entries[g].valid && (entries[g].lpage == lpage);
    end

    always_comb begin
        hit = |hit_vec;
        ppn = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                ppn = PIDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlate_addr_form.sv
module xlate_addr_form
    import xlate_pkg::*;
#(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned PIDX_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              super_mode,
    input  logic [1:0]        pg_sel,
    input  logic              hit,
    input  logic [PIDX_W-1:0] ppn,
    output logic [ADDR_W-1:0] out_addr,
    output region_e           region,
    output logic              abort
);

    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(1) << (ADDR_W - 1);

    int unsigned       ob;
    logic [ADDR_W-1:0] off_mask;
    logic [ADDR_W-3:0] win_off;
    logic              in_range;

    always_comb begin
        ob       = off_bits(pg_sel);
        off_mask = (ADDR_W'(1) << ob) - ADDR_W'(1);
        win_off  = addr[ADDR_W-3:0];
        in_range = (win_off >> (ob + PIDX_W)) == '0;

        out_addr = '0;
        abort    = 1'b0;
        if (!addr[ADDR_W-1]) begin
            region = RGN_LOGICAL;
            if (hit) begin
                out_addr = WIN_BASE | (ADDR_W'(ppn) << ob) | (addr & off_mask);
            end else begin
                abort = 1'b1;
            end
        end else if (!addr[ADDR_W-2]) begin
            region = RGN_PHYSWIN;
            if (super_mode && in_range) begin
                out_addr = addr;
            end else begin
                abort = 1'b1;
            end
        end else begin
            region   = RGN_ROMIO;
            out_addr = addr;
        end
    end

endmodule

// File: rtl/pagemap_xlate.sv
module pagemap_xlate
    import xlate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 26,
    parameter int unsigned NUM_PAGES = 128,
    parameter int unsigned PIDX_W    = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pg_size_sel,
    input  logic              tbl_wr_en,
    input  logic [PIDX_W-1:0] tbl_wr_page,
    input  logic              tbl_wr_valid,
    input  logic [LPN_W-1:0]  tbl_wr_lpage,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_super,
    output logic [ADDR_W-1:0] xl_addr,
    output logic [1:0]        xl_region,
    output logic              xl_abort
);

    localparam int unsigned LOG_W = ADDR_W - 1;

    map_entry_t [NUM_PAGES-1:0] entries;
    map_entry_t                 wr_entry;
    logic [ADDR_W-1:0]          eff_addr;
    logic                       hit;
    logic [PIDX_W-1:0]          ppn;
    region_e                    region;

    assign wr_entry = '{valid: tbl_wr_valid, lpage: tbl_wr_lpage};
    assign eff_addr = req_word ? {req_addr[ADDR_W-1:2], 2'b00} : req_addr;

    xlate_map_table #(.NUM_PAGES(NUM_PAGES), .PIDX_W(PIDX_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_page  (tbl_wr_page),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    xlate_page_match #(.NUM_PAGES(NUM_PAGES), .PIDX_W(PIDX_W), .LOG_W(LOG_W)) i_match (
        .entries  (entries),
        .log_addr (eff_addr[LOG_W-1:0]),
        .pg_sel   (pg_size_sel),
        .hit      (hit),
        .ppn      (ppn)
    );

    xlate_addr_form #(.ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) i_form (
        .addr       (eff_addr),
        .super_mode (req_super),
        .pg_sel     (pg_size_sel),
        .hit        (hit),
        .ppn        (ppn),
        .out_addr   (xl_addr),
        .region     (region),
        .abort      (xl_abort)
    );

    assign xl_region = region;

    assert_region_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_addr[ADDR_W-1] |-> xl_region == RGN_LOGICAL);
    assert_hit_targets_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_region == RGN_LOGICAL && !xl_abort) |-> xl_addr[ADDR_W-1:ADDR_W-2] == 2'b10);
    assert_abort_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xl_abort |-> xl_addr == '0);
    assert_winner_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> entries[ppn].valid);
    assert_user_window_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[ADDR_W-1:ADDR_W-2] == 2'b10 && !req_super) |-> xl_abort);
    assert_romio_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !xl_abort);
    assert_word_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_word |-> xl_addr[1:0] == 2'b00);

endmodule

// File: tb/test_pagemap_xlate.sv
module test_pagemap_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pg_size_sel = 2'd1;
    logic        tbl_wr_en = 1'b0;
    logic [6:0]  tbl_wr_page = '0;
    logic        tbl_wr_valid = 1'b0;
    logic [12:0] tbl_wr_lpage = '0;
    logic [25:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_super = 1'b0;
    logic [25:0] xl_addr;
    logic [1:0]  xl_region;
    logic        xl_abort;

    int checks = 0;
    int errors = 0;
    bit ref_valid [128];
    int ref_lpn   [128];

    always #2 clk = ~clk;

    pagemap_xlate i_pagemap_xlate (
        .clk(clk), .rst_n(rst_n), .pg_size_sel(pg_size_sel),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_page(tbl_wr_page),
        .tbl_wr_valid(tbl_wr_valid), .tbl_wr_lpage(tbl_wr_lpage),
        .req_addr(req_addr), .req_word(req_word), .req_super(req_super),
        .xl_addr(xl_addr), .xl_region(xl_region), .xl_abort(xl_abort)
    );

    function automatic void model(input int a, input int sel, input bit word,
                                  input bit sup, output int ea, output int er,
                                  output bit eb);
        int pg = 4096 << sel;
        int a2 = word ? (a & ~3) : a;
        int lp;
        int found = -1;
        ea = 0; eb = 0;
        if (a2 < 32'h2000000) begin
            er = 0;
            lp = a2 / pg;
            for (int i = 127; i >= 0; i--)
                if (ref_valid[i] && ref_lpn[i] == lp) found = i;
            if (found >= 0) ea = 32'h2000000 + found * pg + (a2 % pg);
            else eb = 1;
        end else if (a2 < 32'h3000000) begin
            er = 1;
            if (!sup || (a2 - 32'h2000000) >= 128 * pg) eb = 1;
            else ea = a2;
        end else begin
            er = 2;
            ea = a2;
        end
    endfunction

    task automatic compare(input string tag);
        int ea, er;
        bit eb;
        model(int'(req_addr), int'(pg_size_sel), req_word, req_super, ea, er, eb);
        checks++;
        if (xl_addr !== 26'(ea) || xl_region !== 2'(er) || xl_abort !== eb) begin
            errors++;
            $display("FAIL %s addr=%h req=%h: got addr=%h rgn=%0d abort=%0b expected addr=%h rgn=%0d abort=%0b",
                     tag, req_addr, req_addr, xl_addr, xl_region, xl_abort, 26'(ea), er, eb);
        end
    endtask

    // Drive at negedge, compare 1 ns later, apply the table write to the model at the posedge.
    task automatic step(input int a, input bit word, input bit sup, input string tag);
        @(negedge clk);
        req_addr  = 26'(a);
        req_word  = word;
        req_super = sup;
        #1;
        compare(tag);
        @(posedge clk);
        if (tbl_wr_en) begin
            ref_valid[tbl_wr_page] = tbl_wr_valid;
            ref_lpn[tbl_wr_page]   = int'(tbl_wr_lpage);
        end
        #1;
        tbl_wr_en = 1'b0;
    endtask

    task automatic set_write(input int page, input bit v, input int lpn);
        tbl_wr_en    = 1'b1;
        tbl_wr_page  = 7'(page);
        tbl_wr_valid = v;
        tbl_wr_lpage = 13'(lpn);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin ref_valid[i] = 0; ref_lpn[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset: everything invalid, so logical accesses abort (R3)
        step(32'h0001234, 0, 1, "R11_reset_R3");
        step(32'h0006000, 0, 0, "R3_miss");

        // R11: write is not visible in the same cycle, visible after the edge
        set_write(5, 1, 3);
        step(3 * 8192 + 16, 0, 0, "R11_before_edge");
        step(3 * 8192 + 16, 0, 0, "R2_hit");
        step(3 * 8192 + 8191, 0, 1, "R2_hit_top");
        // R10 word masking vs byte
        step(3 * 8192 + 16'h0123, 1, 0, "R10_word");
        step(3 * 8192 + 16'h0123, 0, 0, "R10_byte");

        // R5 collisions: lowest physical page wins
        set_write(9, 1, 3);
        step(32'h0000000, 0, 0, "R5_setup");
        set_write(2, 1, 3);
        step(32'h0000000, 0, 0, "R5_setup2");
        step(3 * 8192 + 4, 0, 0, "R5_lowest");
        // R12 invalidate the winner
        set_write(2, 0, 3);
        step(3 * 8192 + 4, 0, 0, "R12_before_edge");
        step(3 * 8192 + 4, 0, 0, "R12_fallback");

        // R4 page sizes
        for (int s = 0; s < 4; s++) begin
            pg_size_sel = 2'(s);
            step((3 * (4096 << s)) + 100, 0, 0, "R4_size");
            step((4 * (4096 << s)) + 100, 0, 0, "R4_size_miss");
        end

        // R6/R7/R8 physical window
        pg_size_sel = 2'd1;
        step(32'h2000100, 0, 1, "R6_super");
        step(32'h20FFFFF, 0, 1, "R6_last");
        step(32'h2000100, 0, 0, "R7_user");
        step(32'h2100000, 0, 1, "R8_beyond");
        pg_size_sel = 2'd3;
        step(32'h2100000, 0, 1, "R6_big");
        step(32'h2400000, 0, 1, "R8_beyond_big");
        pg_size_sel = 2'd0;
        step(32'h2080000, 0, 1, "R8_beyond_small");

        // R9 ROM/IO, R1 region boundaries
        step(32'h3FFFFFF, 0, 0, "R9_user");
        step(32'h3FFFFFF, 1, 1, "R9_word_R10");
        step(32'h3000000, 0, 0, "R9_base");
        step(32'h1FFFFFF, 0, 0, "R1_logical_top");
        step(32'h1000000, 0, 1, "R1_logical_mid");

        // Random phase: narrow logical page range to force collisions
        for (int k = 0; k < 600; k++) begin
            int a;
            int r = int'($urandom_range(0, 9));
            if ((k % 50) == 0) pg_size_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 2) == 0)
                set_write(int'($urandom_range(0, 127)), 1'($urandom_range(0, 3) != 0),
                          int'($urandom_range(0, 15)));
            if (r < 6)
                a = int'($urandom_range(0, 15)) * (4096 << pg_size_sel)
                    + int'($urandom_range(0, (4096 << pg_size_sel) - 1));
            else
                a = int'($urandom_range(0, 32'h3FFFFFF));
            step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 "R2_R5_R6_R7_R8_R9_random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule